// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block works out the output frequency of a fractional-N PLL from its reference frequency and the divider settings packed into two control words. The first word carries the integer feedback multiplier, the reference pre-divider and the post-divider exponent. The second word carries a 16-bit fractional addend to the multiplier. The rate is the reference times the 16.16 fixed-point multiplier, divided by the pre-divider scaled by 65536 and by two raised to the post-divider exponent.

A pulse on `start` samples the inputs. The block builds the 64-bit numerator in one step, then runs a restoring divider that settles one quotient bit per clock. When the result is ready, `done` pulses once. A zero pre-divider is reported through `err` and no division takes place. An integer-only mode input ignores the fractional word.

Top module: `pll_rate_calc`

## Requirements
- R1: After a run completes, `rate` holds the low 32 bits of floor(ref × (M × 65536 + K) / (P × 65536 × 2^S)), and `err` is 0.
- R2: In `div_word0`, M is read from bits 21:12, P from bits 9:4 and S from bits 2:0. All other bits of that word have no effect.
- R3: K is read from bits 15:0 of `div_word1`. Bits 31:16 of that word have no effect.
- R4: While `int_only` is 1 at the accepting edge, K is taken as zero and `div_word1` has no effect.
- R5: The product ref × (M × 65536 + K) is kept at full 64-bit width before the division. A full-scale reference with maximum M and K gives the exact truncated quotient.
- R6: For a nonzero P, `busy` is 1 from the accepting edge until the result edge. `done` is 1 for exactly one cycle, starting 65 clock edges after the edge that accepted `start`, and `busy` is 0 in that cycle.
- R7: If P is zero, the accepting edge sets `done` for one cycle, with `err` = 1 and `rate` = 0. `busy` stays 0.
- R8: `start` has no effect while `busy` is 1. The result is the one for the inputs sampled at the accepting edge, and only one `done` pulse occurs.
- R9: After reset, `busy`, `done` and `err` are 0 and `rate` is 0.
- R10: When idle and `start` is low, `rate` and `err` keep their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to evaluate the current inputs |
| int_only | input | 1 | Treat the fraction as zero |
| ref_rate | input | 32 | Reference frequency |
| div_word0 | input | 32 | Word with multiplier, pre-divider and post-divider exponent |
| div_word1 | input | 32 | Word with the fractional multiplier term |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Last request had a zero pre-divider |
| rate | output | 32 | Computed output frequency |

## Verification
The bench goes after the following corner cases and what a wrong design would do in each:
- **Intermediate width.** A full-scale reference with maximum M and K checks the product width. A design that truncated the product to 32 bits would return a small, wrong rate.
- **Field placement.** Junk is set in every unused bit of both words. A mispositioned mask would pull junk into M, P, S or K.
- **Integer-only mode.** An integer-only run is made with a nonzero fraction word. A design that honoured that word would return the fractional rate.
- **Zero pre-divider.** A zero P must give an immediate error and a zero rate, not a 64-cycle run or an all-ones quotient.
- **Start while busy.** A second `start` in mid-run, carrying different inputs, would restart or corrupt a design that accepted it.
- **Latency and pulse shape.** Off-by-one faults in the divider counter show up as a `done` at the wrong edge or a pulse longer than one cycle.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
    // Default field widths of the divider words
    localparam int WORD_W = 32;
    localparam int MUL_W  = 10;
    localparam int PRE_W  = 6;
    localparam int POST_W = 3;
    localparam int FRAC_W = 16;
    localparam int REF_W  = 32;
    localparam int OUT_W  = 32;
    localparam int DIV_W  = 64;

    // Field positions decoded from the control words
    localparam int MUL_LSB  = 12;
    localparam int PRE_LSB  = 4;
    localparam int POST_LSB = 0;
    localparam int FRAC_LSB = 0;
endpackage

// File: rtl/pll_field_unpack.sv
module pll_field_unpack
    import pll_calc_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_MUL  = MUL_W,
    parameter int W_PRE  = PRE_W,
    parameter int W_POST = POST_W,
    parameter int W_FRAC = FRAC_W
) (
    input  logic [W_WORD-1:0] word0_i,
    input  logic [W_WORD-1:0] word1_i,
    input  logic              int_only_i,
    output logic [W_MUL-1:0]  mul_o,
    output logic [W_PRE-1:0]  pre_o,
    output logic [W_POST-1:0] post_o,
    output logic [W_FRAC-1:0] frac_o
);
    always_comb begin
        mul_o  = word0_i[MUL_LSB  +: W_MUL];
        pre_o  = word0_i[PRE_LSB  +: W_PRE];
        post_o = word0_i[POST_LSB +: W_POST];
        frac_o = int_only_i ? '0 : word1_i[FRAC_LSB +: W_FRAC];
    end
endmodule

// File: rtl/pll_num_build.sv
module pll_num_build
    import pll_calc_pkg::*;
#(
    parameter int W_REF  = REF_W,
    parameter int W_MUL  = MUL_W,
    parameter int W_PRE  = PRE_W,
    parameter int W_POST = POST_W,
    parameter int W_FRAC = FRAC_W,
    parameter int W_DIV  = DIV_W
) (
    input  logic [W_REF-1:0]  ref_i,
    input  logic [W_MUL-1:0]  mul_i,
    input  logic [W_FRAC-1:0] frac_i,
    input  logic [W_PRE-1:0]  pre_i,
    input  logic [W_POST-1:0] post_i,
    output logic [W_DIV-1:0]  dividend_o,
    output logic [W_DIV-1:0]  divisor_o,
    output logic              pre_zero_o
);
    localparam int W_SCALE = W_MUL + W_FRAC;
    localparam int W_PROD  = W_REF + W_SCALE;

    logic [W_SCALE-1:0] scale;
    logic [W_PROD-1:0]  product;

    always_comb begin
        // M*2^FRAC_W + K is the concatenation of both fields
        scale      = {mul_i, frac_i};
        product    = W_PROD'(ref_i) * W_PROD'(scale);
        dividend_o = W_DIV'(product);
        divisor_o  = W_DIV'(pre_i) << (W_FRAC + int'(post_i));
        pre_zero_o = (pre_i == '0);
    end

    initial begin
        assert (W_PROD <= W_DIV) else $error("product wider than divider");
    end
endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div
    import pll_calc_pkg::*;
#(
    parameter int W_DIV = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W_DIV-1:0] dividend_i,
    input  logic [W_DIV-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [W_DIV-1:0] quot_o
);
    localparam int W_CNT = $clog2(W_DIV);
    localparam logic [W_CNT-1:0] LAST = W_CNT'(W_DIV - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [W_CNT-1:0] cnt;
        logic [W_DIV-1:0] num;
        logic [W_DIV-1:0] den;
        logic [W_DIV:0]   rem;
        logic [W_DIV-1:0] quo;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W_DIV:0] trial;
    logic [W_DIV:0] diff;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = {st_q.rem[W_DIV-1:0], st_q.num[W_DIV-1]};
        diff      = trial - {1'b0, st_q.den};
        if (st_q.busy) begin
            if (!diff[W_DIV]) begin
                st_d.rem = diff;
                st_d.quo = {st_q.quo[W_DIV-2:0], 1'b1};
            end else begin
                st_d.rem = trial;
                st_d.quo = {st_q.quo[W_DIV-2:0], 1'b0};
            end
            st_d.num = st_q.num << 1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.num  = dividend_i;
            st_d.den  = divisor_i;
            st_d.rem  = '0;
            st_d.quo  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign quot_o = st_q.quo;

    // R1: a finished division leaves a remainder below the divisor
    a_r1_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.rem < {1'b0, st_q.den}));

    // R8: a start during a run neither restarts nor stops it early
    a_r8_run_survives_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i && st_q.cnt != LAST) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_calc_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_REF  = REF_W,
    parameter int W_OUT  = OUT_W,
    parameter int W_MUL  = MUL_W,
    parameter int W_PRE  = PRE_W,
    parameter int W_POST = POST_W,
    parameter int W_FRAC = FRAC_W,
    parameter int W_DIV  = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              int_only,
    input  logic [W_REF-1:0]  ref_rate,
    input  logic [W_WORD-1:0] div_word0,
    input  logic [W_WORD-1:0] div_word1,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [W_OUT-1:0]  rate
);
    typedef struct packed {
        logic             run;
        logic             done;
        logic             err;
        logic [W_OUT-1:0] rate;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [W_MUL-1:0]  mul;
    logic [W_PRE-1:0]  pre;
    logic [W_POST-1:0] post;
    logic [W_FRAC-1:0] frac;
    logic [W_DIV-1:0]  dividend;
    logic [W_DIV-1:0]  divisor;
    logic              pre_zero;
    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [W_DIV-1:0]  quot;

    pll_field_unpack #(
        .W_WORD(W_WORD), .W_MUL(W_MUL), .W_PRE(W_PRE),
        .W_POST(W_POST), .W_FRAC(W_FRAC)
    ) i_unpack (
        .word0_i(div_word0), .word1_i(div_word1), .int_only_i(int_only),
        .mul_o(mul), .pre_o(pre), .post_o(post), .frac_o(frac)
    );

    pll_num_build #(
        .W_REF(W_REF), .W_MUL(W_MUL), .W_PRE(W_PRE),
        .W_POST(W_POST), .W_FRAC(W_FRAC), .W_DIV(W_DIV)
    ) i_num (
        .ref_i(ref_rate), .mul_i(mul), .frac_i(frac), .pre_i(pre), .post_i(post),
        .dividend_o(dividend), .divisor_o(divisor), .pre_zero_o(pre_zero)
    );

    assign div_start = start && !st_q.run && !pre_zero;

    pll_seq_div #(.W_DIV(W_DIV)) i_div (
        .clk(clk), .rst_n(rst_n), .start_i(div_start),
        .dividend_i(dividend), .divisor_i(divisor),
        .busy_o(div_busy), .done_o(div_done), .quot_o(quot)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.run) begin
            if (div_done) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
                st_d.err  = 1'b0;
                st_d.rate = quot[W_OUT-1:0];
            end
        end else if (start) begin
            if (pre_zero) begin
                st_d.done = 1'b1;
                st_d.err  = 1'b1;
                st_d.rate = '0;
            end else begin
                st_d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.run;
    assign done = st_q.done;
    assign err  = st_q.err;
    assign rate = st_q.rate;

    // R7: zero pre-divider answers at once with an error and a zero rate
    a_r7_zero_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.run && pre_zero) |=> (st_q.done && st_q.err && st_q.rate == '0 && !st_q.run));

    // R6: done is a single-cycle pulse
    a_r6_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R6: done never overlaps busy
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.run);

    // R6: the control run flag and the divider agree while dividing
    a_r6_div_tracks_run: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> st_q.run);

    // R10: idle without start keeps the result
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !start) |=> ($stable(st_q.rate) && $stable(st_q.err)));
endmodule

// File: tb/test_pll_rate_calc.sv
module test_pll_rate_calc;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LATENCY    = 65;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        int_only = 1'b0;
    logic [31:0] ref_rate = '0;
    logic [31:0] div_word0 = '0;
    logic [31:0] div_word1 = '0;
    logic        busy, done, err;
    logic [31:0] rate;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    pll_rate_calc i_pll_rate_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .int_only(int_only),
        .ref_rate(ref_rate), .div_word0(div_word0), .div_word1(div_word1),
        .busy(busy), .done(done), .err(err), .rate(rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // word0: M at 21:12, P at 9:4, S at 2:0, junk in the other bits
    function automatic logic [31:0] mk_w0(int m, int p, int s, logic [31:0] junk);
        logic [31:0] w;
        w = junk & ~32'h003F_F3F7;
        w[21:12] = 10'(m);
        w[9:4]   = 6'(p);
        w[2:0]   = 3'(s);
        return w;
    endfunction

    function automatic logic [31:0] model(logic [31:0] r, logic [31:0] w0, logic [31:0] w1, bit io);
        longint unsigned m, p, s, k, num, den;
        m = w0[21:12]; p = w0[9:4]; s = w0[2:0];
        k = io ? 0 : w1[15:0];
        if (p == 0) return 0;
        num = longint'(r) * (m * 65536 + k);
        den = (p * 65536) << s;
        return 32'(num / den);
    endfunction

    // Issue start, return edges from accepting edge to done (0 = same cycle)
    task automatic run(input logic [31:0] r, w0, w1, input bit io, output int lat);
        @(negedge clk);
        ref_rate = r; div_word0 = w0; div_word1 = w1; int_only = io; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_check(input string req, input logic [31:0] r, w0, w1, input bit io);
        int lat;
        logic [31:0] exp;
        exp = model(r, w0, w1, io);
        run(r, w0, w1, io, lat);
        check({req, " rate"}, rate, exp);
        check({req, " err"}, err, (w0[9:4] == 0));
        check({req, " R6 latency"}, lat, (w0[9:4] == 0) ? 0 : LATENCY);
        @(negedge clk);
        check({req, " R6 done pulse width"}, done, 0);
    endtask

    initial begin
        int lat;
        int pulses;
        logic [31:0] held;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 err", err, 0);
        check("R9 rate", rate, 0);
        rst_n = 1'b1;

        // R1 table points
        run(32'd24000000, mk_w0(225, 3, 0, 0), 0, 1'b0, lat);
        check("R1 1.8 GHz point", rate, 32'd1800000000);
        check("R6 latency table point", lat, LATENCY);
        run(32'd24000000, mk_w0(262, 2, 3, 0), 32'd9437, 1'b0, lat);
        check("R1 fractional point", rate, 32'd393215995);

        // R6 busy right after accept
        @(negedge clk);
        ref_rate = 32'd24000000; div_word0 = mk_w0(200, 3, 1, 0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 busy after accept", busy, 1);
        while (!done) @(negedge clk);
        check("R6 busy low at done", busy, 0);

        // R2 junk in unused word0 bits, R3 junk in word1 high bits
        run_check("R2", 32'd27000000, mk_w0(300, 5, 2, 32'hFFFF_FFFF), 32'h0000_1234, 1'b0);
        run_check("R3", 32'd24000000, mk_w0(173, 2, 1, 0), 32'hABCD_4000, 1'b0);
        // R4 integer-only ignores word1
        run(32'd24000000, mk_w0(262, 2, 3, 0), 32'hFFFF_FFFF, 1'b1, lat);
        check("R4 int_only rate", rate, 32'd786000000 >> 1);
        // R5 full-scale product
        run_check("R5", 32'hFFFF_FFFF, mk_w0(1023, 63, 7, 0), 32'h0000_FFFF, 1'b0);
        run_check("R5 small P", 32'h0123_4567, mk_w0(1023, 63, 0, 0), 32'h0000_FFFF, 1'b0);
        // R7 zero pre-divider
        run_check("R7", 32'd24000000, mk_w0(225, 0, 0, 0), 0, 1'b0);
        check("R7 busy stays low", busy, 0);
        // R1 after an error clears err
        run_check("R1 after err", 32'd24000000, mk_w0(250, 3, 1, 0), 0, 1'b0);

        // R8 start while busy
        @(negedge clk);
        ref_rate = 32'd24000000; div_word0 = mk_w0(300, 3, 2, 0); div_word1 = 0; int_only = 0;
        start = 1'b1;
        @(negedge clk);
        ref_rate = 32'd19200000; div_word0 = mk_w0(100, 1, 0, 0); div_word1 = 32'h7777;
        repeat (10) @(negedge clk);
        start = 1'b0;
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            if (done) pulses++;
            if (done) held = rate;
            @(negedge clk);
        end
        check("R8 single done", pulses, 1);
        check("R8 rate from first inputs", held, 32'd600000000);

        // R10 hold while idle with changing inputs
        held = rate;
        for (int i = 0; i < 8; i++) begin
            ref_rate = $urandom; div_word0 = $urandom; div_word1 = $urandom; int_only = 1'(i);
            @(negedge clk);
        end
        check("R10 rate held", rate, held);
        check("R10 err held", err, 0);

        // R1 random mix
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r, w0, w1;
            r  = $urandom % 32'd100000000;
            w0 = mk_w0($urandom % 1024, ($urandom % 8 == 0) ? 0 : ($urandom % 63) + 1, $urandom % 8, $urandom);
            w1 = $urandom;
            run_check("R1 random", r, w0, w1, 1'($urandom % 4 == 0));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule